// File: doc/BRIEF.md
# Multi-Mode Video Pixel Capture

This block sits at the front of a video input path. It takes two 10-bit pixel channels, A and B, and a per-cycle qualifier that marks which input cycles carry a sample. It turns them into one stream of luma/chroma pairs, or of raw words, with a single output-valid strobe. A small configuration register picks one of three capture modes:

- **Interleaved standard-definition capture:** channel A carries chroma and luma samples in turn.
- **Dual-channel high-definition capture:** luma arrives on B while chroma arrives on A in the same cycle.
- **Raw capture:** one chosen channel is passed straight through.

Every pair carries a tag that says whether its chroma is Cb or Cr.

A four-state phase machine tracks where the stream stands in the chroma/luma interleave. Its states are `PH_CB` (expect Cb), `PH_Y_CB` (expect the luma that follows a Cb), `PH_CR` (expect Cr) and `PH_Y_CR` (expect the luma that follows a Cr).

- In interleaved mode, each valid sample moves it around the ring in this order: `PH_CB`→`PH_Y_CB`→`PH_CR`→`PH_Y_CR`→`PH_CB`.
- In dual-channel mode it toggles `PH_CB`↔`PH_CR` on each valid cycle.
- In raw mode it holds its state.
- A write that changes the mode sends it back to `PH_CB`.

A write that changes the mode while a sample is valid discards that sample and raises a sticky error flag. Software clears the flag by writing 1.

Top module: `vcap_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every output is 0, the mode is interleaved (code 2'b00), raw select is channel A, and the phase is `PH_CB`.
- R2: Interleaved mode (code 2'b00) takes its samples from channel A only, in the order Cb, Y, Cr, Y. The sample taken in `PH_CB` or `PH_CR` is held. The sample taken in `PH_Y_CB` or `PH_Y_CR` is emitted as the luma, paired with the held chroma. `out_is_cr` is 0 for a Cb pair and 1 for a Cr pair. Channel B has no effect.
- R3: Dual-channel mode (code 2'b01) emits a pair on every valid cycle, with luma from channel B and chroma from channel A of the same cycle. `out_is_cr` alternates 0, 1, 0, … starting at 0 after reset or a mode change.
- R4: Raw mode (code 2'b10) emits `out_raw` on every valid cycle. The value comes from channel A when the raw select is 0 and from channel B when it is 1.
- R5: A cycle with `in_valid` low produces no `out_valid`, does not advance the phase, and changes no output.
- R6: `out_valid` rises in the cycle after the sample's capture edge. While it is low, all data outputs hold their values. In interleaved and dual-channel modes only `out_luma`, `out_chroma` and `out_is_cr` are updated; in raw modes only `out_raw` is updated.
- R7: A configuration write whose mode field differs from the current mode is a mode change. It drops that cycle's sample, and the phase restarts at `PH_CB`. The new mode and raw select apply from the next cycle. A write that keeps the mode updates the raw select from the next cycle and keeps the sample.
- R8: A mode change written while `in_valid` is high sets `err_flag`. The flag stays set until a cycle with `err_clr` high and no new error; a new error in the same cycle as `err_clr` wins.
- R9: Mode code 2'b11 behaves exactly as raw mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode_in | input | 2 | Mode to write: 00 interleaved, 01 dual-channel, 10/11 raw |
| cfg_rawsel_in | input | 1 | Raw channel select to write: 0 = A, 1 = B |
| err_clr | input | 1 | Write-1 clear of the error flag |
| in_valid | input | 1 | Qualifies ch_a and ch_b this cycle |
| ch_a | input | 10 | Pixel channel A |
| ch_b | input | 10 | Pixel channel B |
| out_valid | output | 1 | One-cycle strobe: new output word(s) present |
| out_luma | output | 10 | Luma of the emitted pair |
| out_chroma | output | 10 | Chroma of the emitted pair |
| out_is_cr | output | 1 | 1 when out_chroma is Cr, 0 when Cb |
| out_raw | output | 10 | Raw captured word |
| err_flag | output | 1 | Sticky mode-change-under-valid error |

## Verification
A phase machine that is one step out of place shows at the ports on the next pair. In interleaved mode the luma and chroma trade places and the Cb/Cr tag flips within two valid samples; in dual-channel mode the tag inverts on the very next valid cycle. A missed phase reset after a mode change therefore shows within one pair. A lost valid gate shows as an extra `out_valid` one cycle after an idle input. The bench compares every output in every cycle against an independent model, so any of these faults appears the cycle it occurs.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        MODE_SD      = 2'b00,
        MODE_HD      = 2'b01,
        MODE_RAW     = 2'b10,
        MODE_RAW_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PH_CB   = 2'b00,
        PH_Y_CB = 2'b01,
        PH_CR   = 2'b10,
        PH_Y_CR = 2'b11
    } phase_e;

endpackage

// File: rtl/vcap_cfg.sv
module vcap_cfg
    import vcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode_in,
    input  logic       cfg_rawsel_in,
    input  logic       err_clr,
    input  logic       in_valid,
    output mode_e      mode_q,
    output logic       rawsel_q,
    output logic       mode_chg,
    output logic       err_flag
);

    assign mode_chg = cfg_we && (mode_e'(cfg_mode_in) != mode_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_SD;
            rawsel_q <= 1'b0;
        end else if (cfg_we) begin
            mode_q   <= mode_e'(cfg_mode_in);
            rawsel_q <= cfg_rawsel_in;
        end
    end

    // a new error outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (mode_chg && in_valid)
            err_flag <= 1'b1;
        else if (err_clr)
            err_flag <= 1'b0;
    end

endmodule

// File: rtl/vcap_fsm.sv
module vcap_fsm
    import vcap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  mode_e  mode,
    input  logic   in_valid,
    input  logic   mode_chg,
    output phase_e phase_q,
    output logic   take_chroma,
    output logic   emit_pair,
    output logic   pair_is_cr,
    output logic   emit_raw
);

    phase_e phase_d;
    logic   adv;

    assign adv = in_valid && !mode_chg;

    // next-state process
    always_comb begin
        phase_d = phase_q;
        if (mode_chg) begin
            phase_d = PH_CB;
        end else if (adv) begin
            unique case (mode)
                MODE_SD: begin
                    unique case (phase_q)
                        PH_CB:   phase_d = PH_Y_CB;
                        PH_Y_CB: phase_d = PH_CR;
                        PH_CR:   phase_d = PH_Y_CR;
                        PH_Y_CR: phase_d = PH_CB;
                    endcase
                end
                MODE_HD: begin
                    phase_d = (phase_q == PH_CR) ? PH_CB : PH_CR;
                end
                MODE_RAW, MODE_RAW_ALT: phase_d = phase_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_CB;
        else
            phase_q <= phase_d;
    end

    // output decode
    always_comb begin
        take_chroma = 1'b0;
        emit_pair   = 1'b0;
        pair_is_cr  = 1'b0;
        emit_raw    = 1'b0;
        if (adv) begin
            unique case (mode)
                MODE_SD: begin
                    unique case (phase_q)
                        PH_CB, PH_CR: take_chroma = 1'b1;
                        PH_Y_CB: emit_pair = 1'b1;
                        PH_Y_CR: begin
                            emit_pair  = 1'b1;
                            pair_is_cr = 1'b1;
                        end
                    endcase
                end
                MODE_HD: begin
                    emit_pair  = 1'b1;
                    pair_is_cr = (phase_q == PH_CR);
                end
                MODE_RAW, MODE_RAW_ALT: emit_raw = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/vcap_outreg.sv
module vcap_outreg
    import vcap_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          rawsel,
    input  logic [DW-1:0] ch_a,
    input  logic [DW-1:0] ch_b,
    input  logic          take_chroma,
    input  logic          emit_pair,
    input  logic          pair_is_cr,
    input  logic          emit_raw,
    output logic          out_valid,
    output logic [DW-1:0] out_luma,
    output logic [DW-1:0] out_chroma,
    output logic          out_is_cr,
    output logic [DW-1:0] out_raw
);

    logic [DW-1:0] chroma_hold;
    logic [DW-1:0] luma_src;
    logic [DW-1:0] chroma_src;

    // dual-channel: luma on B, chroma on A; interleaved: both from A
    assign luma_src   = (mode == MODE_HD) ? ch_b : ch_a;
    assign chroma_src = (mode == MODE_HD) ? ch_a : chroma_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chroma_hold <= '0;
            out_valid   <= 1'b0;
            out_luma    <= '0;
            out_chroma  <= '0;
            out_is_cr   <= 1'b0;
            out_raw     <= '0;
        end else begin
            out_valid <= emit_pair || emit_raw;
            if (take_chroma)
                chroma_hold <= ch_a;
            if (emit_pair) begin
                out_luma   <= luma_src;
                out_chroma <= chroma_src;
                out_is_cr  <= pair_is_cr;
            end
            if (emit_raw)
                out_raw <= rawsel ? ch_b : ch_a;
        end
    end

endmodule

// File: rtl/vcap_top.sv
module vcap_top
    import vcap_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode_in,
    input  logic          cfg_rawsel_in,
    input  logic          err_clr,
    input  logic          in_valid,
    input  logic [DW-1:0] ch_a,
    input  logic [DW-1:0] ch_b,
    output logic          out_valid,
    output logic [DW-1:0] out_luma,
    output logic [DW-1:0] out_chroma,
    output logic          out_is_cr,
    output logic [DW-1:0] out_raw,
    output logic          err_flag
);

    mode_e  mode_q;
    phase_e phase_q;
    logic   rawsel_q;
    logic   mode_chg;
    logic   take_chroma;
    logic   emit_pair;
    logic   pair_is_cr;
    logic   emit_raw;

    vcap_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_mode_in  (cfg_mode_in),
        .cfg_rawsel_in(cfg_rawsel_in),
        .err_clr      (err_clr),
        .in_valid     (in_valid),
        .mode_q       (mode_q),
        .rawsel_q     (rawsel_q),
        .mode_chg     (mode_chg),
        .err_flag     (err_flag)
    );

    vcap_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .in_valid   (in_valid),
        .mode_chg   (mode_chg),
        .phase_q    (phase_q),
        .take_chroma(take_chroma),
        .emit_pair  (emit_pair),
        .pair_is_cr (pair_is_cr),
        .emit_raw   (emit_raw)
    );

    vcap_outreg #(.DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .rawsel     (rawsel_q),
        .ch_a       (ch_a),
        .ch_b       (ch_b),
        .take_chroma(take_chroma),
        .emit_pair  (emit_pair),
        .pair_is_cr (pair_is_cr),
        .emit_raw   (emit_raw),
        .out_valid  (out_valid),
        .out_luma   (out_luma),
        .out_chroma (out_chroma),
        .out_is_cr  (out_is_cr),
        .out_raw    (out_raw)
    );

endmodule

// File: rtl/vcap_top_chk.sv
module vcap_top_chk #(
    parameter int DW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_mode_in,
    input logic          err_clr,
    input logic          in_valid,
    input logic          out_valid,
    input logic [DW-1:0] out_luma,
    input logic [DW-1:0] out_chroma,
    input logic          out_is_cr,
    input logic [DW-1:0] out_raw,
    input logic          err_flag,
    input logic [1:0]    mode_q,
    input logic [1:0]    phase_q
);

    logic chg;
    assign chg = cfg_we && (cfg_mode_in != mode_q);

    a_r5_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_luma) && $stable(out_chroma)
                        && $stable(out_is_cr) && $stable(out_raw)));

    a_r7_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (phase_q == 2'b00));

    a_r7_sample_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !out_valid);

    a_r8_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && in_valid) |=> err_flag);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

endmodule

bind vcap_top vcap_top_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_mode_in(cfg_mode_in),
    .err_clr    (err_clr),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_luma   (out_luma),
    .out_chroma (out_chroma),
    .out_is_cr  (out_is_cr),
    .out_raw    (out_raw),
    .err_flag   (err_flag),
    .mode_q     (mode_q),
    .phase_q    (phase_q)
);

// File: tb/tb_vcap_top.sv
`timescale 1ns/1ps
module tb_vcap_top;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_mode_in;
    logic          cfg_rawsel_in;
    logic          err_clr;
    logic          in_valid;
    logic [DW-1:0] ch_a;
    logic [DW-1:0] ch_b;
    logic          out_valid;
    logic [DW-1:0] out_luma;
    logic [DW-1:0] out_chroma;
    logic          out_is_cr;
    logic [DW-1:0] out_raw;
    logic          err_flag;

    always #2 clk = ~clk;

    vcap_top #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode_in(cfg_mode_in),
        .cfg_rawsel_in(cfg_rawsel_in), .err_clr(err_clr), .in_valid(in_valid),
        .ch_a(ch_a), .ch_b(ch_b), .out_valid(out_valid), .out_luma(out_luma),
        .out_chroma(out_chroma), .out_is_cr(out_is_cr), .out_raw(out_raw),
        .err_flag(err_flag)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference model state
    logic [1:0]    m_mode = 2'b00;
    logic          m_sel  = 1'b0;
    int            m_ph   = 0;
    logic [DW-1:0] m_hold = '0;
    logic          e_ov   = 1'b0;
    logic [DW-1:0] e_luma = '0;
    logic [DW-1:0] e_chr  = '0;
    logic          e_cr   = 1'b0;
    logic [DW-1:0] e_raw  = '0;
    logic          e_err  = 1'b0;

    function automatic string data_tag(input logic [1:0] md, input bit chg, input logic ov);
        if (chg)       return "R7";
        if (!ov)       return "R6";
        case (md)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic model(input logic we, input logic [1:0] md, input logic sel,
                         input logic clr, input logic v,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
        bit chg;
        chg  = we && (md != m_mode);
        e_ov = 1'b0;
        if (!chg && v) begin
            case (m_mode)
                2'b00: begin
                    case (m_ph)
                        0: begin m_hold = a; m_ph = 1; end
                        1: begin e_luma = a; e_chr = m_hold; e_cr = 1'b0; e_ov = 1'b1; m_ph = 2; end
                        2: begin m_hold = a; m_ph = 3; end
                        default: begin e_luma = a; e_chr = m_hold; e_cr = 1'b1; e_ov = 1'b1; m_ph = 0; end
                    endcase
                end
                2'b01: begin
                    e_luma = b; e_chr = a; e_ov = 1'b1;
                    e_cr = (m_ph == 2);
                    m_ph = (m_ph == 2) ? 0 : 2;
                end
                default: begin
                    e_raw = m_sel ? b : a; e_ov = 1'b1;
                end
            endcase
        end
        if (chg) m_ph = 0;
        if (chg && v) e_err = 1'b1;
        else if (clr) e_err = 1'b0;
        if (we) begin m_mode = md; m_sel = sel; end
    endtask

    task automatic cmp(input string tag, input string nm, input int act, input int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
            bad = 1;
        end
    endtask

    task automatic check_all(input string dtag);
        bit bad = 0;
        vectors++;
        cmp("R5", "out_valid",  out_valid,  e_ov,   bad);
        cmp(dtag, "out_luma",   out_luma,   e_luma, bad);
        cmp(dtag, "out_chroma", out_chroma, e_chr,  bad);
        cmp(dtag, "out_is_cr",  out_is_cr,  e_cr,   bad);
        cmp(dtag, "out_raw",    out_raw,    e_raw,  bad);
        cmp("R8", "err_flag",   err_flag,   e_err,  bad);
        if (bad) fails++;
    endtask

    // drive at negedge, capture at posedge, check at following negedge
    task automatic step(input logic we, input logic [1:0] md, input logic sel,
                        input logic clr, input logic v,
                        input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [1:0] old_mode;
        bit chg;
        old_mode = m_mode;
        chg = we && (md != m_mode);
        cfg_we = we; cfg_mode_in = md; cfg_rawsel_in = sel;
        err_clr = clr; in_valid = v; ch_a = a; ch_b = b;
        model(we, md, sel, clr, v, a, b);
        @(posedge clk);
        @(negedge clk);
        check_all(data_tag(old_mode, chg, e_ov));
    endtask

    task automatic sample(input logic [DW-1:0] a, input logic [DW-1:0] b);
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, a, b);
    endtask

    task automatic idle();
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, $urandom, $urandom);
    endtask

    task automatic set_mode(input logic [1:0] md, input logic sel);
        step(1'b1, md, sel, 1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            $display("FAIL watchdog expired");
            fails++;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; cfg_we = 0; cfg_mode_in = 0; cfg_rawsel_in = 0;
        err_clr = 0; in_valid = 0; ch_a = 0; ch_b = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check_all("R1");

        // R2: interleaved Cb Y Cr Y on A, B toggling must not matter
        sample(10'h101, 10'h3FF); sample(10'h202, 10'h000);
        sample(10'h103, 10'h155); sample(10'h204, 10'h2AA);
        // R5: gap in the middle of a pair
        sample(10'h111, 10'h0F0); idle(); idle(); sample(10'h222, 10'h0F0);

        // R3: dual-channel, tag starts at Cb
        set_mode(2'b01, 1'b0);
        sample(10'h011, 10'h3A1); sample(10'h012, 10'h3A2);
        idle(); sample(10'h013, 10'h3A3);

        // R4: raw from A then B (R7 select-only write keeps mode)
        set_mode(2'b10, 1'b0);
        sample(10'h055, 10'h0AA);
        step(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 10'h066, 10'h099);
        sample(10'h077, 10'h088);
        // R9: code 11 acts as raw
        set_mode(2'b11, 1'b1);
        sample(10'h1C3, 10'h23C);

        // R7 + R8: mode change under valid drops sample, raises error
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 10'h3E0, 10'h01F);
        sample(10'h100, 10'h0); sample(10'h200, 10'h0);
        // R8: clear and new error in same cycle: error wins
        step(1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 10'h001, 10'h002);
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 10'h0, 10'h0);
        // R7: SD left mid-pair, back to SD restarts at Cb
        set_mode(2'b00, 1'b0);
        sample(10'h301, 10'h0);
        set_mode(2'b01, 1'b0); set_mode(2'b00, 1'b0);
        sample(10'h302, 10'h0); sample(10'h303, 10'h0);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic we, clr, v;
            we  = ($urandom % 16) == 0;
            clr = ($urandom % 16) == 0;
            v   = ($urandom % 4) != 0;
            step(we, 2'($urandom), 1'($urandom), clr, v, DW'($urandom), DW'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule